// File: doc/BRIEF.md
# Manchester Line Encoder with Clear-to-Send Sequencing

This block turns a serial NRZ bit stream into Manchester code on a pair of complementary line outputs, `bip_one` and `bip_zero`. It runs from a single sample clock whose rate is 16 or 32 times the bit rate. The `mode_32x` input picks the rate, and one data bit period (DBP) is 16 or 32 clock cycles.

A transmission starts when the active-low `cts_n` goes from high to low. The outputs stay quiet for one DBP. They then carry a preamble of eight alternating bits. A sync header follows, made of two 1.5-DBP runs of opposite level, and `sync_sel` picks which level comes first. Eleven DBP after the start, the block drives an encode clock (`enc_clk`) to the serial source. Each rising edge of that clock captures one bit from `sdata_in`, and the block codes that bit onto the line during the following bit period.

When `cts_n` returns high, no new encode clock pulse begins. The last captured bit is sent in full, and then both outputs fall low.

Top module: `mce_encoder`

## Requirements
- R1: When `mode_32x`=0 one DBP is 16 cycles, and when it is 1 one DBP is 32 cycles. The mode is sampled only on the clock edge that detects the start of a transmission.
- R2: After a synchronous reset, and at any time while no transmission is in progress, `bip_one`, `bip_zero` and `enc_clk` are all low.
- R3: A transmission starts on the first clock edge at which `cts_n` is sampled low after being sampled high. Counting that edge as edge 0, both line outputs stay low up to and including edge DBP. From edge DBP+1 they carry eight preamble bit periods. In each of these, `bip_one` takes the sync polarity in the first half and its inverse in the second half.
- R4: After the preamble, `bip_one` holds the sync polarity for 1.5 DBP and then its inverse for 1.5 DBP. The sync polarity is `sync_sel` sampled at the start edge: 1 means high first (command sync) and 0 means low first (data sync).
- R5: Counting bit period 0 as the one that begins at the start edge, `enc_clk` is high for the first half of each bit period from bit period 11 onward and low for the second half. Its first rising edge appears 11 DBP plus one cycle after the start edge.
- R6: A bit is captured from `sdata_in` on the clock edge at which `enc_clk` rises, and it is sent in the next bit period. A 1 drives `bip_one` high then low, and a 0 drives it low then high, with the level change at mid-bit.
- R7: While the outputs are active, `bip_zero` is the inverse of `bip_one`. `bip_one` and `bip_zero` are never high at the same time.
- R8: Once `cts_n` is sampled high during a transmission, no encode clock pulse starts at any later bit boundary. A pulse that has already started keeps its full half-bit width.
- R9: After the encode clock stops, the bit period that carries the last captured bit completes. Both outputs go low at the boundary that follows it.
- R10: If `cts_n` is sampled high before the encode clock has started, the outputs go low at the next bit boundary and no encode clock pulse is produced.
- R11: A high-to-low change of `cts_n` during a transmission does not cancel a stop that was already requested. Holding `cts_n` low after the block has gone idle does not start a new transmission.
- R12: Changes to `sync_sel` and `mode_32x` after the start edge have no effect on the transmission in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 or 32 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| mode_32x | input | 1 | Rate select: 0 for 16 cycles per bit, 1 for 32 cycles per bit |
| sync_sel | input | 1 | Sync polarity: 1 for command sync (high first), 0 for data sync (low first) |
| cts_n | input | 1 | Active-low clear-to-send |
| sdata_in | input | 1 | Serial NRZ data, captured on the rising edge of `enc_clk` |
| enc_clk | output | 1 | Encode clock to the serial data source |
| bip_one | output | 1 | True line output, low when disabled |
| bip_zero | output | 1 | Complement line output, low when disabled |

## Verification
The checker assumes that every input is synchronous to `clk`. It also assumes that `cts_n` is a level that can change in any cycle, including on the last cycle of a half-bit, and that `sdata_in` may toggle freely between encode clock edges. The bench changes all inputs on the falling clock edge. It drives `sdata_in` from a shift register that moves every cycle, so a bit captured one cycle early or late would show up as a different code on the line. It places the stop request at several offsets relative to bit boundaries, including a brief high pulse on `cts_n`, and it changes `sync_sel` and `mode_32x` in the middle of a transmission.

// File: rtl/mce_pkg.sv
package mce_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/mce_timebase.sv
module mce_timebase #(
  parameter int HALF_LO = 8,
  parameter int HALF_HI = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic mode_hi,
  output logic cyc_zero,
  output logic tick
);
  localparam int CW = (HALF_HI > 1) ? $clog2(HALF_HI) : 1;
  localparam logic [CW-1:0] LAST_LO = CW'(HALF_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(HALF_HI - 1);

  logic [CW-1:0] cyc;
  logic          hi_q;
  logic [CW-1:0] last;

  assign last = hi_q ? LAST_HI : LAST_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= '0;
      hi_q <= 1'b0;
    end else if (restart) begin
      cyc  <= '0;
      hi_q <= mode_hi;
    end else if (run) begin
      cyc <= (cyc == last) ? '0 : cyc + 1'b1;
    end
  end

  assign cyc_zero = run && (cyc == '0);
  assign tick     = run && (cyc == last);
endmodule

// File: rtl/mce_sequencer.sv
module mce_sequencer
  import mce_pkg::*;
#(
  parameter int HW     = 5,
  parameter int DATA_H = 24,
  parameter int CLK_H  = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cts_n,
  input  logic          sync_sel,
  input  logic          sdata,
  input  logic          cyc_zero,
  input  logic          tick,
  output logic          start,
  output logic          running,
  output logic [HW-1:0] half,
  output logic          pol,
  output logic          cur_bit,
  output logic          run_clk
);
  seq_st_e       st;
  logic [HW-1:0] h, hn;
  logic          cts_prev, stop_q, pend_q, pend_v;
  logic          stop_now, leaving;

  assign start    = (st == ST_IDLE) && !cts_n && cts_prev;
  assign running  = (st == ST_RUN);
  assign stop_now = stop_q | cts_n;
  // half index saturates by toggling between the two data halves
  assign hn       = (h == HW'(DATA_H + 1)) ? HW'(DATA_H) : h + 1'b1;
  assign leaving  = (hn < HW'(DATA_H)) ? stop_now : !pend_v;
  assign half     = h;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      h        <= '0;
      cts_prev <= 1'b1;
      stop_q   <= 1'b0;
      run_clk  <= 1'b0;
      pend_q   <= 1'b0;
      pend_v   <= 1'b0;
      cur_bit  <= 1'b0;
      pol      <= 1'b0;
    end else begin
      cts_prev <= cts_n;
      if (st == ST_IDLE) begin
        if (start) begin
          st      <= ST_RUN;
          h       <= '0;
          stop_q  <= 1'b0;
          run_clk <= 1'b0;
          pend_v  <= 1'b0;
          pol     <= sync_sel;
        end
      end else begin
        if (cts_n) stop_q <= 1'b1;
        if (run_clk && !h[0] && cyc_zero) begin
          pend_q <= sdata;
          pend_v <= 1'b1;
        end
        if (tick) begin
          if (!h[0]) begin
            h <= hn;
          end else if (leaving) begin
            st      <= ST_IDLE;
            run_clk <= 1'b0;
            h       <= '0;
          end else begin
            h       <= hn;
            run_clk <= (hn >= HW'(CLK_H)) && !stop_now;
            cur_bit <= pend_q;
            pend_v  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mce_linecoder.sv
module mce_linecoder #(
  parameter int HW     = 5,
  parameter int SYNC_H = 18,
  parameter int DATA_H = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          running,
  input  logic [HW-1:0] half,
  input  logic          pol,
  input  logic          cur_bit,
  input  logic          run_clk,
  output logic          bip_one,
  output logic          bip_zero,
  output logic          enc_clk
);
  logic active, lvl;

  always_comb begin
    active = running && (half >= HW'(2));
    if (half < HW'(SYNC_H))          lvl = half[0] ? ~pol : pol;
    else if (half < HW'(SYNC_H + 3)) lvl = pol;
    else if (half < HW'(DATA_H))     lvl = ~pol;
    else                             lvl = half[0] ? ~cur_bit : cur_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bip_one  <= 1'b0;
      bip_zero <= 1'b0;
      enc_clk  <= 1'b0;
    end else begin
      bip_one  <= active & lvl;
      bip_zero <= active & ~lvl;
      enc_clk  <= running & run_clk & ~half[0];
    end
  end
endmodule

// File: rtl/mce_encoder.sv
module mce_encoder #(
  parameter int OVS_LO   = 16,
  parameter int OVS_HI   = 32,
  parameter int PRE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_32x,
  input  logic sync_sel,
  input  logic cts_n,
  input  logic sdata_in,
  output logic enc_clk,
  output logic bip_one,
  output logic bip_zero
);
  localparam int SYNC_H = 2 + 2 * PRE_BITS;
  localparam int DATA_H = SYNC_H + 6;
  localparam int CLK_H  = DATA_H - 2;
  localparam int HW     = $clog2(DATA_H + 2);

  logic          start, seq_running, cyc_zero, tick;
  logic [HW-1:0] half;
  logic          pol, cur_bit, run_clk;

  mce_timebase #(.HALF_LO(OVS_LO / 2), .HALF_HI(OVS_HI / 2)) u_tb (
    .clk(clk), .rst(rst), .restart(start), .run(seq_running),
    .mode_hi(mode_32x), .cyc_zero(cyc_zero), .tick(tick)
  );

  mce_sequencer #(.HW(HW), .DATA_H(DATA_H), .CLK_H(CLK_H)) u_seq (
    .clk(clk), .rst(rst), .cts_n(cts_n), .sync_sel(sync_sel), .sdata(sdata_in),
    .cyc_zero(cyc_zero), .tick(tick), .start(start), .running(seq_running),
    .half(half), .pol(pol), .cur_bit(cur_bit), .run_clk(run_clk)
  );

  mce_linecoder #(.HW(HW), .SYNC_H(SYNC_H), .DATA_H(DATA_H)) u_lc (
    .clk(clk), .rst(rst), .running(seq_running), .half(half), .pol(pol),
    .cur_bit(cur_bit), .run_clk(run_clk), .bip_one(bip_one),
    .bip_zero(bip_zero), .enc_clk(enc_clk)
  );
endmodule

// File: rtl/mce_checker.sv
module mce_checker (
  input logic clk,
  input logic rst,
  input logic cts_n,
  input logic enc_clk,
  input logic bip_one,
  input logic bip_zero,
  input logic running
);
  // R2: an idle sequencer leaves every output low one register later
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !running |=> (!bip_one && !bip_zero && !enc_clk));

  // R7: the two line outputs are never high together
  p_never_both_r7: assert property (@(posedge clk) disable iff (rst)
    !(bip_one && bip_zero));

  // R5: the encode clock only runs while the line is driven
  p_clk_with_line_r5: assert property (@(posedge clk) disable iff (rst)
    enc_clk |-> (bip_one != bip_zero));

  // R5: an encode clock pulse is wider than one cycle
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(enc_clk) |=> enc_clk);

  // R8: a pulse only starts if clear-to-send was low at the deciding boundary
  p_rise_needs_cts_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(enc_clk) |-> !$past(cts_n, 2));
endmodule

bind mce_encoder mce_checker u_chk (
  .clk(clk), .rst(rst), .cts_n(cts_n), .enc_clk(enc_clk),
  .bip_one(bip_one), .bip_zero(bip_zero), .running(seq_running)
);

// File: tb/mce_encoder_tb.sv
module mce_encoder_tb;
  localparam int OVS_LO   = 16;
  localparam int OVS_HI   = 32;
  localparam int PRE_BITS = 8;
  localparam int SYNC_H   = 2 + 2 * PRE_BITS;
  localparam int DATA_H   = SYNC_H + 6;
  localparam int CLK_H    = DATA_H - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_32x = 1'b0, sync_sel = 1'b1, cts_n = 1'b1, sdata_in = 1'b0;
  logic enc_clk, bip_one, bip_zero;

  always #4 clk = ~clk;

  mce_encoder #(.OVS_LO(OVS_LO), .OVS_HI(OVS_HI), .PRE_BITS(PRE_BITS)) u_dut (
    .clk(clk), .rst(rst), .mode_32x(mode_32x), .sync_sel(sync_sel),
    .cts_n(cts_n), .sdata_in(sdata_in), .enc_clk(enc_clk),
    .bip_one(bip_one), .bip_zero(bip_zero)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, cmp_on = 0;
  string scen = "";
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s%s at cycle %0d: actual=%b expected=%b", tag, scen, cyc, act, exp);
    end
  endtask

  // behavioural reference: absolute time since start, queues of captured bits
  int  m_run, m_t, m_hb, m_pol, m_stop, m_prev;
  bit  m_bits[$];
  bit  m_clk[$];
  logic e_b1 = 0, e_b0 = 0, e_ck = 0;
  string t_b1 = "R2", t_ck = "R2";

  always @(posedge clk) begin : model
    int hf, nh;
    logic lvl;
    bit leave;
    if (rst) begin
      m_run = 0; m_prev = 1; e_b1 = 0; e_b0 = 0; e_ck = 0; t_b1 = "R2"; t_ck = "R2";
    end else begin
      if (m_run == 0) begin
        e_b1 = 0; e_b0 = 0; e_ck = 0; t_b1 = "R2"; t_ck = "R2";
      end else begin
        hf = m_t / m_hb;
        if (hf < SYNC_H) begin
          lvl = (hf % 2 == 0) ? m_pol[0] : !m_pol[0]; t_b1 = "R3";
        end else if (hf < SYNC_H + 3) begin
          lvl = m_pol[0]; t_b1 = "R4";
        end else if (hf < DATA_H) begin
          lvl = !m_pol[0]; t_b1 = "R4";
        end else begin
          lvl = m_bits[(hf - DATA_H) / 2];
          if (hf % 2 == 1) lvl = !lvl;
          t_b1 = (m_stop != 0) ? "R9" : "R6";
        end
        if (m_stop != 0 && hf < CLK_H) t_b1 = "R10";
        if (m_hb == OVS_HI / 2) t_b1 = {t_b1, "/R1"};
        e_b1 = (hf >= 2) && lvl;
        e_b0 = (hf >= 2) && !lvl;
        e_ck = (hf >= CLK_H) && (hf % 2 == 0) && m_clk[(hf - CLK_H) / 2];
        t_ck = (m_stop != 0) ? "R8" : "R5";
      end
      if (m_run == 0) begin
        if (!cts_n && m_prev != 0) begin
          m_run = 1; m_t = 0; m_hb = mode_32x ? OVS_HI / 2 : OVS_LO / 2;
          m_pol = sync_sel; m_stop = 0; m_bits.delete(); m_clk.delete();
        end
      end else begin
        if (cts_n) m_stop = 1;
        hf = m_t / m_hb;
        if (m_t % m_hb == 0 && hf >= CLK_H && hf % 2 == 0 && m_clk[(hf - CLK_H) / 2])
          m_bits.push_back(sdata_in);
        if ((m_t + 1) % m_hb == 0 && ((m_t + 1) / m_hb) % 2 == 0) begin
          nh = (m_t + 1) / m_hb;
          if (nh < DATA_H) leave = (m_stop != 0);
          else leave = (m_bits.size() <= (nh - DATA_H) / 2);
          if (leave) m_run = 0;
          else begin
            if (nh >= CLK_H) m_clk.push_back(m_stop == 0);
            m_t++;
          end
        end else m_t++;
      end
      m_prev = cts_n;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(bip_one === e_b1, t_b1, bip_one, e_b1);
      check(bip_zero === e_b0, "R7", bip_zero, e_b0);
      check(enc_clk === e_ck, t_ck, enc_clk, e_ck);
    end
  end

  // serial source that moves every cycle
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sdata_in = lfsr[0];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    cmp_on = 1;
    wait_cyc(1);
    check(!bip_one && !bip_zero && !enc_clk, "R2 reset", {bip_one, bip_zero, enc_clk} != 0, 1'b0);

    // command sync, 16x; mode and sync select disturbed mid-run
    scen = " R12"; mode_32x = 0; sync_sel = 1; cts_n = 0;
    wait_cyc(40); sync_sel = 0; mode_32x = 1;
    wait_cyc(18 * 16 + 3); cts_n = 1;
    wait_cyc(4 * 32); mode_32x = 0;

    // data sync, 32x
    scen = " R1"; mode_32x = 1; sync_sel = 0; cts_n = 0;
    wait_cyc(16 * 32 + 5); mode_32x = 0; cts_n = 1;
    wait_cyc(5 * 32);

    // abort during preamble
    scen = " R10"; sync_sel = 1; cts_n = 0;
    wait_cyc(3 * 16 + 3); cts_n = 1;
    wait_cyc(3 * 16);
    check(!bip_one && !bip_zero, "R10 idle", bip_one | bip_zero, 1'b0);

    // brief high pulse on cts_n during data, then held low
    scen = " R11"; cts_n = 0;
    wait_cyc(14 * 16 + 7); cts_n = 1;
    wait_cyc(2); cts_n = 0;
    wait_cyc(6 * 16);
    check(!bip_one && !bip_zero && !enc_clk, "R11 no restart", bip_one | bip_zero | enc_clk, 1'b0);
    cts_n = 1; wait_cyc(3);

    // stop requested on the last cycle before a boundary
    scen = " R8"; sync_sel = 0; cts_n = 0;
    wait_cyc(15 * 16 - 1); cts_n = 1;
    wait_cyc(4 * 16);
    check(!bip_one && !bip_zero, "R9 idle", bip_one | bip_zero, 1'b0);

    // reset in the middle of data
    scen = " R2"; sync_sel = 1; cts_n = 0;
    wait_cyc(13 * 16 + 4); rst = 1;
    wait_cyc(2);
    check(!bip_one && !bip_zero && !enc_clk, "R2 mid reset", bip_one | bip_zero | enc_clk, 1'b0);
    cts_n = 1; rst = 0;
    wait_cyc(10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule